// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the completion events of a multi-channel DMA engine and turns them into a single interrupt request. Each channel raises one-cycle pulses for three kinds of event: half of a transfer moved, one descriptor finished, and the whole descriptor queue finished. Every pulse latches a pending flag. Software reads and acknowledges these flags through a small word-wide register bus.

Each channel owns a four-bit group. Three of its bits are used and the top bit is reserved. Channels 0 to 7 sit in the first enable word and the first pending word. Channels 8 to 15 sit in the second pair. A separate enable bit for every flag masks it from the interrupt line. The number of channels is a parameter, and the groups of channels that are not built read as zero. Pending flags are cleared by writing ones to them. Software normally writes all ones once at start-up.

The block holds no state machine. Each channel group is a set of independent flag registers, and the interrupt line is a single register stage that follows them.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, all four registers read zero and `irq_o` is low.
- R2: A one-cycle pulse on an event input sets its pending flag at that clock edge, whether or not the flag is enabled.
- R3: Channel n is held in word n/8 (enable at address 0x00 or 0x04, pending at 0x10 or 0x14). Its group starts at bit (n mod 8)*4. Inside a group, bit 0 is half-transfer, bit 1 is descriptor-done and bit 2 is queue-done.
- R4: A write to a pending word clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: When an event pulse and a clearing write hit the same flag in the same cycle, the flag stays set.
- R6: A write to an enable word stores bits 0 to 2 of each group, and a read returns them.
- R7: Bit 3 of every group reads as zero in both enable and pending words, and writes to it have no effect.
- R8: `irq_o` goes high one clock after any flag is both pending and enabled. A pending flag that is not enabled never raises `irq_o`.
- R9: Groups of channels at or above `NUM_CH` read as zero, even after a write of all ones.
- R10: An address other than the four listed reads as zero, and a write to it changes no register.
- R11: `irq_o` drops one clock after the last enabled pending flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Write strobe, sampled at the clock edge |
| reg_addr_i | input | ADDR_W | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| evt_half_i | input | NUM_CH | Half-transfer pulse, one bit per channel |
| evt_desc_i | input | NUM_CH | Descriptor-done pulse, one bit per channel |
| evt_queue_i | input | NUM_CH | Queue-done pulse, one bit per channel |
| irq_o | output | 1 | Registered interrupt request |

## Verification
If a flag register is wrong, the error shows up at once on the read port whenever software addresses the matching word. That includes a flag set at the wrong bit position, a clear that was lost, or a reserved bit that holds a value. The same fault in an enabled flag reaches `irq_o` exactly one clock later, so a stuck or missing interrupt appears within one cycle of the cause. An absent channel that holds state would show as nonzero upper bits in the second word.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int MAX_CH     = 16;
    localparam int GRP_W      = 4;
    localparam int KIND_N     = 3;
    localparam int WORD_W     = 32;
    localparam int CH_PER_WD  = WORD_W / GRP_W;
    localparam int FLAT_W     = MAX_CH * GRP_W;

    localparam int K_HALF  = 0;
    localparam int K_DESC  = 1;
    localparam int K_QUEUE = 2;

    localparam logic [7:0] A_ENA0 = 8'h00;
    localparam logic [7:0] A_ENA1 = 8'h04;
    localparam logic [7:0] A_PND0 = 8'h10;
    localparam logic [7:0] A_PND1 = 8'h14;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_ENA0,
        RS_ENA1,
        RS_PND0,
        RS_PND1
    } reg_sel_e;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);
    always_comb begin
        unique case (addr_i)
            ADDR_W'(A_ENA0): sel_o = RS_ENA0;
            ADDR_W'(A_ENA1): sel_o = RS_ENA1;
            ADDR_W'(A_PND0): sel_o = RS_PND0;
            ADDR_W'(A_PND1): sel_o = RS_PND1;
            default:         sel_o = RS_NONE;
        endcase
    end
endmodule

// File: rtl/irq_agg_chan.sv
module irq_agg_chan
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ena_wr_i,
    input  logic              pnd_clr_i,
    input  logic [KIND_N-1:0] wgrp_i,
    input  logic [KIND_N-1:0] evt_i,
    output logic [KIND_N-1:0] ena_o,
    output logic [KIND_N-1:0] pnd_o
);
    logic [KIND_N-1:0] clr_mask;

    always_comb begin
        clr_mask = pnd_clr_i ? wgrp_i : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_o <= '0;
            pnd_o <= '0;
        end else begin
            if (ena_wr_i) begin
                ena_o <= wgrp_i;
            end
            // a new event outranks a clear in the same cycle
            pnd_o <= (pnd_o & ~clr_mask) | evt_i;
        end
    end
endmodule

// File: rtl/irq_agg_rdmux.sv
module irq_agg_rdmux
    import irq_agg_pkg::*;
(
    input  reg_sel_e            sel_i,
    input  logic [FLAT_W-1:0]   ena_flat_i,
    input  logic [FLAT_W-1:0]   pnd_flat_i,
    output logic [WORD_W-1:0]   rdata_o
);
    always_comb begin
        unique case (sel_i)
            RS_ENA0: rdata_o = ena_flat_i[WORD_W-1:0];
            RS_ENA1: rdata_o = ena_flat_i[FLAT_W-1:WORD_W];
            RS_PND0: rdata_o = pnd_flat_i[WORD_W-1:0];
            RS_PND1: rdata_o = pnd_flat_i[FLAT_W-1:WORD_W];
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic [NUM_CH-1:0] evt_half_i,
    input  logic [NUM_CH-1:0] evt_desc_i,
    input  logic [NUM_CH-1:0] evt_queue_i,
    output logic              irq_o
);
    reg_sel_e          sel;
    logic [FLAT_W-1:0] ena_flat;
    logic [FLAT_W-1:0] pnd_flat;
    logic [1:0]        ena_wsel;
    logic [1:0]        pnd_wsel;

    irq_agg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (reg_addr_i),
        .sel_o  (sel)
    );

    always_comb begin
        ena_wsel = {reg_wr_i && (sel == RS_ENA1), reg_wr_i && (sel == RS_ENA0)};
        pnd_wsel = {reg_wr_i && (sel == RS_PND1), reg_wr_i && (sel == RS_PND0)};
    end

    for (genvar i = 0; i < MAX_CH; i++) begin : g_ch
        localparam int WD   = i / CH_PER_WD;
        localparam int BASE = (i % CH_PER_WD) * GRP_W;
        if (i < NUM_CH) begin : g_live
            logic [KIND_N-1:0] ena_q;
            logic [KIND_N-1:0] pnd_q;
            logic [KIND_N-1:0] evt;
            always_comb begin
                evt = '0;
                evt[K_HALF]  = evt_half_i[i];
                evt[K_DESC]  = evt_desc_i[i];
                evt[K_QUEUE] = evt_queue_i[i];
            end
            irq_agg_chan u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .ena_wr_i  (ena_wsel[WD]),
                .pnd_clr_i (pnd_wsel[WD]),
                .wgrp_i    (reg_wdata_i[BASE +: KIND_N]),
                .evt_i     (evt),
                .ena_o     (ena_q),
                .pnd_o     (pnd_q)
            );
            assign ena_flat[i*GRP_W +: GRP_W] = {1'b0, ena_q};
            assign pnd_flat[i*GRP_W +: GRP_W] = {1'b0, pnd_q};
        end else begin : g_absent
            assign ena_flat[i*GRP_W +: GRP_W] = '0;
            assign pnd_flat[i*GRP_W +: GRP_W] = '0;
        end
    end

    irq_agg_rdmux u_rd (
        .sel_i      (sel),
        .ena_flat_i (ena_flat),
        .pnd_flat_i (pnd_flat),
        .rdata_o    (reg_rdata_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |(ena_flat & pnd_flat);
        end
    end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [31:0]       reg_wdata_i,
    input logic [31:0]       reg_rdata_o,
    input logic [NUM_CH-1:0] evt_half_i,
    input logic [NUM_CH-1:0] evt_desc_i,
    input logic [NUM_CH-1:0] evt_queue_i,
    input logic [FLAT_W-1:0] ena_flat,
    input logic [FLAT_W-1:0] pnd_flat,
    input logic              irq_o
);
    logic [FLAT_W-1:0] evt_flat;
    logic              addr_known;

    always_comb begin
        evt_flat = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            evt_flat[c*GRP_W + K_HALF]  = evt_half_i[c];
            evt_flat[c*GRP_W + K_DESC]  = evt_desc_i[c];
            evt_flat[c*GRP_W + K_QUEUE] = evt_queue_i[c];
        end
        addr_known = (reg_addr_i == ADDR_W'(A_ENA0)) || (reg_addr_i == ADDR_W'(A_ENA1)) ||
                     (reg_addr_i == ADDR_W'(A_PND0)) || (reg_addr_i == ADDR_W'(A_PND1));
    end

    // R8
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(ena_flat & pnd_flat)));

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o & 32'h8888_8888) == 32'h0);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_known |-> reg_rdata_o == 32'h0);

    for (genvar j = 0; j < FLAT_W; j++) begin : g_bit
        localparam int WD = j / WORD_W;
        localparam int BP = j % WORD_W;
        if ((j % GRP_W) != 3 && (j / GRP_W) < NUM_CH) begin : g_used
            // R2
            evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
                evt_flat[j] |=> pnd_flat[j]);
            // R4
            rise_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pnd_flat[j]) |-> $past(evt_flat[j]));
            // R4
            fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pnd_flat[j]) |-> $past(reg_wr_i && reg_wdata_i[BP] &&
                    reg_addr_i == ADDR_W'(WD == 0 ? A_PND0 : A_PND1)));
        end else if ((j / GRP_W) >= NUM_CH) begin : g_gone
            // R9
            absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_addr_i == ADDR_W'(WD == 0 ? A_PND0 : A_PND1) ||
                 reg_addr_i == ADDR_W'(WD == 0 ? A_ENA0 : A_ENA1)) |-> !reg_rdata_o[BP]);
        end
    end
endmodule

bind dma_irq_agg irq_agg_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .evt_half_i  (evt_half_i),
    .evt_desc_i  (evt_desc_i),
    .evt_queue_i (evt_queue_i),
    .ena_flat    (ena_flat),
    .pnd_flat    (pnd_flat),
    .irq_o       (irq_o)
);

// File: tb/dma_irq_agg_bench.sv
`timescale 1ns/1ps
module dma_irq_agg_bench;
    localparam int NCH = 12;
    localparam logic [7:0] EN0 = 8'h00, EN1 = 8'h04, PD0 = 8'h10, PD1 = 8'h14;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [7:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NCH-1:0] ev_h = '0, ev_d = '0, ev_q = '0;
    logic           irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_irq_agg #(.NUM_CH(NCH), .ADDR_W(8)) u_dma_irq_agg (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .evt_half_i(ev_h), .evt_desc_i(ev_d), .evt_queue_i(ev_q), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fbit(input int ch, input int kind);
        return 32'h1 << ((ch % 8) * 4 + kind);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h3c; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 8'h3c;
    endtask

    task automatic pulse(input logic [NCH-1:0] h, input logic [NCH-1:0] dd, input logic [NCH-1:0] q);
        @(negedge clk);
        ev_h = h; ev_d = dd; ev_q = q;
        @(negedge clk);
        ev_h = '0; ev_d = '0; ev_q = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(EN0, v); chk("R1 en0", v, 0);
        rd(EN1, v); chk("R1 en1", v, 0);
        rd(PD0, v); chk("R1 pd0", v, 0);
        rd(PD1, v); chk("R1 pd1", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_set_kinds;
        logic [31:0] v;
        pulse(NCH'(1) << 3, NCH'(1) << 8, NCH'(1) << 11);
        rd(PD0, v); chk("R2 R3 ch3 half", v, fbit(3, 0));
        rd(PD1, v); chk("R2 R3 ch8 desc ch11 queue", v, fbit(8, 1) | fbit(11, 2));
        @(negedge clk);
        chk("R8 masked no irq", {31'b0, irq}, 0);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(PD1, fbit(8, 1));
        rd(PD1, v); chk("R4 w1c", v, fbit(11, 2));
        wr(PD0, 32'h0);
        rd(PD0, v); chk("R4 zero keeps", v, fbit(3, 0));
        wr(PD0, 32'hffff_ffff); wr(PD1, 32'hffff_ffff);
        rd(PD0, v); chk("R4 clear all", v, 0);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        wr(PD0, fbit(5, 2));
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = PD0; reg_wdata = 32'hffff_ffff; ev_d = NCH'(1);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h3c; ev_d = '0;
        rd(PD0, v); chk("R5 set wins", v, fbit(0, 1));
        wr(PD0, 32'hffff_ffff);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        wr(EN0, 32'hffff_ffff);
        rd(EN0, v); chk("R6 R7 en0 readback", v, 32'h7777_7777);
        wr(EN0, 32'h0000_0250);
        rd(EN0, v); chk("R6 en0 pattern", v, 32'h0000_0250);
        wr(EN1, 32'hffff_ffff);
        rd(EN1, v); chk("R9 en1 absent groups", v, 32'h0000_7777);
        wr(EN1, 32'h0);
    endtask

    task automatic t_irq;
        wr(EN0, fbit(1, 1));
        pulse('0, NCH'(1) << 1, '0);
        chk("R8 irq not yet", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R8 irq raised", {31'b0, irq}, 1);
        pulse(NCH'(1) << 1, '0, '0);
        wr(PD0, fbit(1, 1));
        chk("R11 irq still high", {31'b0, irq}, 1);
        @(negedge clk);
        chk("R11 irq dropped", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R8 unenabled half stays low", {31'b0, irq}, 0);
        wr(PD0, 32'hffff_ffff); wr(EN0, 32'h0);
    endtask

    task automatic t_absent;
        logic [31:0] v;
        pulse('1, '1, '1);
        rd(PD0, v); chk("R3 pd0 all", v, 32'h7777_7777);
        rd(PD1, v); chk("R9 pd1 absent", v, 32'h0000_7777);
        wr(PD0, 32'h8888_8888);
        rd(PD0, v); chk("R7 reserved write", v, 32'h7777_7777);
        wr(PD0, 32'hffff_ffff); wr(PD1, 32'hffff_ffff);
        rd(PD1, v); chk("R4 pd1 cleared", v, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(EN0, 32'h0000_0007);
        wr(8'h08, 32'hffff_ffff);
        rd(8'h08, v); chk("R10 unmapped read", v, 0);
        rd(EN0, v); chk("R10 en0 untouched", v, 32'h0000_0007);
        wr(8'h14 ^ 8'h40, 32'hffff_ffff);
        rd(EN1, v); chk("R10 en1 untouched", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_kinds();
        t_clear();
        t_set_wins();
        t_enable();
        t_irq();
        t_absent();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule